// File: doc/BRIEF.md
# Zero-Substitution Transmit Line Encoder

This block sits in the transmit path of a DS3/E3/STS-1 line interface, between the framer and the line driver. It takes one bit per clock period and drives two rail outputs, one for positive pulses and one for negative pulses. In binary format it reads one data bit per period. It turns ones into marks of alternating polarity and replaces long zero runs with substitution codes that carry a deliberate bipolar violation: three-zero runs for DS3/STS-1 (B3ZS) and four-zero runs for E3 (HDB3). In bipolar format the framer already supplies both rails, and the block passes them through unchanged with the same latency.

Input data can be captured on either clock edge, so that the block fits framers that launch on either edge. An internal pattern source can replace framer data with unframed all ones or a repeating one-zero-zero sequence. Pattern data is always line coded.

The block runs at line rate and consumes a bit on every clock. For this reason it has no valid/ready handshake: the line can never be stalled, and back-pressure does not apply. Every configuration input is static and is changed only while reset is asserted.

Top module: `line_zs_tx_encoder`

## Requirements
- R1: With `fmt_bin`=1 and framer data selected, the bit on `dat_pos_in` is line coded and `neg_in` has no effect on the outputs.
- R2: With `line_e3`=0 the substitution length is 3. A run of three zeros is sent as 0,0,V when an odd number of marks has been sent since the last substitution, and as B,0,V when that number is even.
- R3: With `line_e3`=1 the substitution length is 4. A run of four zeros is sent as 0,0,0,V on odd parity and as B,0,0,V on even parity.
- R4: In coded operation, ordinary marks and B pulses take the polarity opposite to the previous pulse. A V pulse repeats the polarity of the previous pulse. `line_pos` and `line_neg` are never high together.
- R5: Synchronous reset (`rst`=1) drives both outputs low, empties the pipeline and sets the mark parity to even. The first pulse after reset is positive (`line_pos`).
- R6: With `fmt_bin`=0 and framer data selected, `{line_pos,line_neg}` equals `{dat_pos_in,neg_in}` as sampled, with no coding.
- R7: With `sample_fall`=0 inputs are captured on the rising clock edge. With `sample_fall`=1 they are captured on the falling edge that precedes it.
- R8: `pat_sel`=2'b01 sends all ones and `pat_sel`=2'b10 sends 1,0,0 repeating, starting with 1 after reset. Both patterns are coded in either format. `pat_sel`=2'b00 and 2'b11 select framer data.
- R9: The pulse for a bit captured at rising edge k is on the outputs after rising edge k+N+1, where N is the substitution length. The outputs stay low until then. The same latency holds in bipolar format.
- R10: Once coding has started, the outputs never show N consecutive empty bit periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_fall | input | 1 | 1 = capture inputs on the falling edge |
| fmt_bin | input | 1 | 1 = binary format (coded), 0 = bipolar pass-through |
| line_e3 | input | 1 | 1 = HDB3 (E3), 0 = B3ZS (DS3/STS-1) |
| pat_sel | input | 2 | 01 all ones, 10 repeating 100, 00/11 framer data |
| dat_pos_in | input | 1 | Binary data, or positive rail in bipolar format |
| neg_in | input | 1 | Negative rail in bipolar format, ignored in binary |
| line_pos | output | 1 | Positive pulse rail |
| line_neg | output | 1 | Negative pulse rail |

## Verification
The hardest case to reach is a substitution that follows another with no marks in between. Here the parity reset caused by the outgoing V must select B,0,V (or B,0,0,V) again with inverted polarity. Long all-zero streams after reset produce this case repeatedly. Sparse random streams, with roughly one mark in five bits, produce many runs that end just short of or just past the substitution length under both parities. To show which edge is used, the bench puts the true bit on the inputs for the half period around the selected edge and puts its complement there around the other edge.

// File: rtl/zs_enc_pkg.sv
package zs_enc_pkg;
  // symbol codes held in each delay slot; in bipolar format the two bits are {pos,neg}
  localparam logic [1:0] SYM_ZERO = 2'd0;
  localparam logic [1:0] SYM_MARK = 2'd1;
  localparam logic [1:0] SYM_BPOL = 2'd2;
  localparam logic [1:0] SYM_VIOL = 2'd3;

  typedef struct packed {
    logic       vld;
    logic [1:0] sym;
  } slot_t;

  localparam logic [1:0] PAT_ONES = 2'b01;
  localparam logic [1:0] PAT_100  = 2'b10;
endpackage

// File: rtl/zs_pattern_gen.sv
module zs_pattern_gen #(
  parameter int PERIOD = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pat_sel,
  output logic       pat_on,
  output logic       pat_bit
);
  import zs_enc_pkg::*;
  localparam int PH_W = $clog2(PERIOD);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst || pat_sel != PAT_100) ph_q <= '0;
    else if (ph_q == PH_W'(PERIOD-1)) ph_q <= '0;
    else ph_q <= ph_q + 1'b1;
  end

  assign pat_on  = (pat_sel == PAT_ONES) || (pat_sel == PAT_100);
  assign pat_bit = (pat_sel == PAT_ONES) ? 1'b1 : (ph_q == '0);
endmodule

// File: rtl/zs_sampler.sv
module zs_sampler (
  input  logic                clk,
  input  logic                rst,
  input  logic                sample_fall,
  input  logic                fmt_bin,
  input  logic                dat_pos_in,
  input  logic                neg_in,
  input  logic                pat_on,
  input  logic                pat_bit,
  input  logic [1:0]          pat_sel,
  output zs_enc_pkg::slot_t   a_slot,
  output logic                enc
);
  import zs_enc_pkg::*;

  logic fall_p_q, fall_n_q;
  logic cap_p, cap_n;
  slot_t a_q;

  // falling-edge capture; handed to the rising-edge core half a period later
  always_ff @(negedge clk) begin
    fall_p_q <= dat_pos_in;
    fall_n_q <= neg_in;
  end

  assign cap_p = sample_fall ? fall_p_q : dat_pos_in;
  assign cap_n = sample_fall ? fall_n_q : neg_in;
  assign enc   = fmt_bin | pat_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
    end else begin
      a_q.vld <= 1'b1;
      if (pat_on)       a_q.sym <= {1'b0, pat_bit};
      else if (fmt_bin) a_q.sym <= {1'b0, cap_p};
      else              a_q.sym <= {cap_p, cap_n};
    end
  end

  assign a_slot = a_q;

  AST_PATTERN_ONES: assert property (@(posedge clk) disable iff (rst) (pat_sel == PAT_ONES) |=> (a_q.vld && a_q.sym == SYM_MARK)); // R8
endmodule

// File: rtl/zs_subst.sv
module zs_subst #(
  parameter int SHORT_LEN = 3,
  parameter int LONG_LEN  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc,
  input  logic              hdb3,
  input  zs_enc_pkg::slot_t in_slot,
  output zs_enc_pkg::slot_t tap_slot
);
  import zs_enc_pkg::*;
  localparam int MAX_LEN = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
  localparam int IDX_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  slot_t line_q [MAX_LEN];
  slot_t line_d [MAX_LEN];
  logic  par_q, par_d;
  logic  run_hit;
  logic [IDX_W-1:0] last_idx;
  slot_t tap;

  assign last_idx = hdb3 ? IDX_W'(LONG_LEN-1) : IDX_W'(SHORT_LEN-1);
  assign tap      = line_q[last_idx];
  assign tap_slot = tap;

  always_comb begin
    // parity of marks sent since the last substitution, including the symbol leaving now
    par_d = par_q;
    if (!enc) par_d = 1'b0;
    else if (tap.vld && tap.sym == SYM_MARK) par_d = ~par_q;
    else if (tap.vld && tap.sym == SYM_VIOL) par_d = 1'b0;

    run_hit = enc && in_slot.vld && (in_slot.sym == SYM_ZERO);
    for (int i = 0; i < MAX_LEN-1; i++) begin
      if (i < int'(last_idx))
        run_hit = run_hit && line_q[i].vld && (line_q[i].sym == SYM_ZERO);
    end

    line_d[0] = in_slot;
    for (int i = 1; i < MAX_LEN; i++) line_d[i] = line_q[i-1];

    if (run_hit) begin
      line_d[0].sym = SYM_VIOL;
      if (!par_d) line_d[last_idx].sym = SYM_BPOL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MAX_LEN; i++) line_q[i] <= '0;
      par_q <= 1'b0;
    end else begin
      for (int i = 0; i < MAX_LEN; i++) line_q[i] <= line_d[i];
      par_q <= par_d;
    end
  end
endmodule

// File: rtl/zs_rail_out.sv
module zs_rail_out #(
  parameter int SHORT_LEN = 3,
  parameter int LONG_LEN  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc,
  input  logic              hdb3,
  input  zs_enc_pkg::slot_t tap_slot,
  output logic              line_pos,
  output logic              line_neg
);
  import zs_enc_pkg::*;
  localparam int CNT_W = $clog2(LONG_LEN + 1) + 1;

  logic pos_q, neg_q, last_neg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= 1'b0;
      neg_q      <= 1'b0;
      last_neg_q <= 1'b1;
    end else if (!tap_slot.vld) begin
      pos_q <= 1'b0;
      neg_q <= 1'b0;
    end else if (!enc) begin
      {pos_q, neg_q} <= tap_slot.sym;
    end else begin
      case (tap_slot.sym)
        SYM_MARK, SYM_BPOL: begin
          pos_q      <= last_neg_q;
          neg_q      <= ~last_neg_q;
          last_neg_q <= ~last_neg_q;
        end
        SYM_VIOL: begin
          pos_q <= ~last_neg_q;
          neg_q <= last_neg_q;
        end
        default: begin
          pos_q <= 1'b0;
          neg_q <= 1'b0;
        end
      endcase
    end
  end

  assign line_pos = pos_q;
  assign line_neg = neg_q;

  // observation state for the checks below
  logic enc_q, is_v_q, out_vld_q, hdb3_q, seen_q, chk_neg_q, pulse;
  logic [CNT_W-1:0] zrun_q;
  assign pulse = pos_q | neg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_q <= 1'b0; is_v_q <= 1'b0; out_vld_q <= 1'b0; hdb3_q <= 1'b0;
      seen_q <= 1'b0; chk_neg_q <= 1'b0; zrun_q <= '0;
    end else begin
      enc_q     <= enc;
      is_v_q    <= enc && tap_slot.vld && (tap_slot.sym == SYM_VIOL);
      out_vld_q <= tap_slot.vld;
      hdb3_q    <= hdb3;
      if (enc_q && pulse) begin
        seen_q    <= 1'b1;
        chk_neg_q <= neg_q;
      end
      if (!enc_q || hdb3 != hdb3_q) zrun_q <= '0;
      else if (out_vld_q) zrun_q <= pulse ? '0 : ((&zrun_q) ? zrun_q : zrun_q + 1'b1);
    end
  end

  AST_RAILS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) enc_q |-> !(pos_q && neg_q)); // R4
  AST_MARK_ALTERNATES: assert property (@(posedge clk) disable iff (rst) (enc_q && pulse && !is_v_q && seen_q) |-> (neg_q != chk_neg_q)); // R4
  AST_VIOL_REPEATS: assert property (@(posedge clk) disable iff (rst) (enc_q && is_v_q && seen_q) |-> (neg_q == chk_neg_q)); // R4
  AST_FIRST_PULSE_POS: assert property (@(posedge clk) disable iff (rst) (enc_q && pulse && !seen_q) |-> pos_q); // R5
  AST_ZERO_RUN_BOUND: assert property (@(posedge clk) disable iff (rst) (enc_q && out_vld_q && !pulse) |-> (zrun_q < CNT_W'((hdb3_q ? LONG_LEN : SHORT_LEN) - 1))); // R10
endmodule

// File: rtl/line_zs_tx_encoder.sv
module line_zs_tx_encoder #(
  parameter int SHORT_LEN  = 3,
  parameter int LONG_LEN   = 4,
  parameter int PAT_PERIOD = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sample_fall,
  input  logic       fmt_bin,
  input  logic       line_e3,
  input  logic [1:0] pat_sel,
  input  logic       dat_pos_in,
  input  logic       neg_in,
  output logic       line_pos,
  output logic       line_neg
);
  import zs_enc_pkg::*;

  logic  pat_on, pat_bit, enc;
  slot_t a_slot, tap_slot;

  zs_pattern_gen #(.PERIOD(PAT_PERIOD)) u_pat (
    .clk(clk), .rst(rst), .pat_sel(pat_sel), .pat_on(pat_on), .pat_bit(pat_bit)
  );

  zs_sampler u_smp (
    .clk(clk), .rst(rst), .sample_fall(sample_fall), .fmt_bin(fmt_bin),
    .dat_pos_in(dat_pos_in), .neg_in(neg_in), .pat_on(pat_on), .pat_bit(pat_bit),
    .pat_sel(pat_sel), .a_slot(a_slot), .enc(enc)
  );

  zs_subst #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_sub (
    .clk(clk), .rst(rst), .enc(enc), .hdb3(line_e3), .in_slot(a_slot), .tap_slot(tap_slot)
  );

  zs_rail_out #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_out (
    .clk(clk), .rst(rst), .enc(enc), .hdb3(line_e3), .tap_slot(tap_slot),
    .line_pos(line_pos), .line_neg(line_neg)
  );
endmodule

// File: tb/line_zs_tx_encoder_tb.sv
`timescale 1ns/1ps
module line_zs_tx_encoder_tb;
  localparam int MAXS = 512;

  logic clk = 1'b0;
  logic rst = 1'b1, sample_fall = 1'b0, fmt_bin = 1'b1, line_e3 = 1'b0;
  logic [1:0] pat_sel = 2'b00;
  logic dat_pos_in = 1'b0, neg_in = 1'b0;
  logic line_pos, line_neg;

  int checks = 0, fails = 0;
  bit in_d [MAXS];
  bit in_n [MAXS];
  logic [1:0] expv [MAXS];
  logic [1:0] obs  [MAXS];

  always #2.5 clk = ~clk;

  line_zs_tx_encoder u_dut (
    .clk(clk), .rst(rst), .sample_fall(sample_fall), .fmt_bin(fmt_bin), .line_e3(line_e3),
    .pat_sel(pat_sel), .dat_pos_in(dat_pos_in), .neg_in(neg_in),
    .line_pos(line_pos), .line_neg(line_neg)
  );

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // reference coder built straight from the requirement text
  task automatic build_expected(int n, bit bin, bit e3, logic [1:0] pat);
    bit enc = bin || pat == 2'b01 || pat == 2'b10;
    int sl = e3 ? 4 : 3;
    bit lneg = 1'b1;
    int marks = 0, z = 0;
    for (int j = 0; j < n; j++) begin
      bit b = (pat == 2'b01) ? 1'b1 : (pat == 2'b10) ? (j % 3 == 0) : in_d[j];
      expv[j] = 2'b00;
      if (!enc) expv[j] = {in_d[j], in_n[j]};
      else if (b) begin
        lneg = ~lneg; expv[j] = {~lneg, lneg}; marks++; z = 0;
      end else begin
        z++;
        if (z == sl) begin
          if (marks % 2 == 0) begin
            lneg = ~lneg; expv[j-sl+1] = {~lneg, lneg};
          end
          expv[j] = {~lneg, lneg};
          marks = 0; z = 0;
        end
      end
    end
  endtask

  task automatic half_edge(bit fall);
    if (fall) @(negedge clk); else @(posedge clk);
    #1;
  endtask
  task automatic drive_edge(bit fall);
    if (fall) @(posedge clk); else @(negedge clk);
    #1;
  endtask

  // kind: 0 random, 1 all zeros, 2 sparse marks
  task automatic run_seg(string tag, bit fall, bit bin, bit e3, logic [1:0] pat, int kind, int nbits);
    int lat = (e3 ? 4 : 3) + 2;
    int tot = nbits + lat;
    for (int j = 0; j < tot; j++) begin
      in_d[j] = (kind == 1) ? 1'b0 : (kind == 2) ? ($urandom % 5 == 0) : 1'($urandom);
      in_n[j] = 1'($urandom);
    end
    build_expected(tot, bin, e3, pat);
    sample_fall = fall; fmt_bin = bin; line_e3 = e3; pat_sel = pat;
    rst = 1'b1; dat_pos_in = 1'b0; neg_in = 1'b0;
    repeat (3) @(posedge clk);
    drive_edge(fall);
    rst = 1'b0;
    for (int s = 0; s < tot; s++) begin
      obs[s] = {line_pos, line_neg};
      if (s == 0) check({tag, " R5 reset state"}, obs[s], 2'b00);
      else if (s < lat) check({tag, " R9 outputs low before latency"}, obs[s], 2'b00);
      else check({tag, $sformatf(" bit %0d", s - lat)}, obs[s], expv[s - lat]);
      dat_pos_in = in_d[s]; neg_in = in_n[s];
      half_edge(fall);
      dat_pos_in = ~in_d[s]; neg_in = ~in_n[s];
      drive_edge(fall);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    run_seg("R1 R2 R4 R10 B3ZS random rise", 0, 1, 0, 2'b00, 0, 300);
    run_seg("R1 R3 R4 R10 HDB3 random rise", 0, 1, 1, 2'b00, 0, 300);
    run_seg("R2 R7 B3ZS sparse fall", 1, 1, 0, 2'b00, 2, 300);
    run_seg("R3 R7 HDB3 sparse fall", 1, 1, 1, 2'b00, 2, 300);
    run_seg("R2 R4 B3ZS sparse rise", 0, 1, 0, 2'b00, 2, 300);
    run_seg("R3 R5 HDB3 zeros", 0, 1, 1, 2'b00, 1, 40);
    // directed: B00V then B00V of opposite polarity, first pulse positive
    check("R5 HDB3 first pulse positive", obs[6], 2'b10);
    check("R3 HDB3 V follows B", obs[9], 2'b10);
    check("R3 HDB3 second B inverts", obs[10], 2'b01);
    check("R3 HDB3 second V", obs[13], 2'b01);
    run_seg("R2 R5 B3ZS zeros", 1, 1, 0, 2'b00, 1, 40);
    check("R5 B3ZS first pulse positive", obs[5], 2'b10);
    check("R2 B3ZS V after B0", obs[7], 2'b10);
    check("R2 B3ZS next B inverts", obs[8], 2'b01);
    run_seg("R6 R9 bipolar rise", 0, 0, 0, 2'b00, 0, 200);
    run_seg("R6 R7 bipolar fall HDB3", 1, 0, 1, 2'b00, 0, 200);
    run_seg("R8 all ones", 0, 1, 0, 2'b01, 0, 120);
    run_seg("R8 100 pattern in bipolar fmt", 1, 0, 1, 2'b10, 0, 120);
    run_seg("R8 reserved select framer data", 0, 1, 1, 2'b11, 0, 150);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule